// File: doc/BRIEF.md
# Multi-Queue Write-Side Space Tracker

This block is the write half of a buffer that holds several independent queues in one storage array. A write interface picks a target queue with a select input and offers words with a write enable. The block keeps an occupancy count and a write pointer for every queue, and turns each accepted word into a one-cycle write command for the shared storage. It drives one space flag per queue, plus a composite flag that follows whichever queue the write port currently selects.

The read side reports each word it removes as a completion event that is already synchronised to the write clock. The block frees that word's space only after a fixed two-cycle delay. A mode input is sampled during reset. Standard mode uses the block's own storage as the whole capacity, and the flag is low when the queue is full. Fall-through mode adds the read side's output register as one more slot, and the flag is high when no more words fit.

Top module: `mqw_write_port`

## Requirements
- R1: `fwft_mode` is captured only while `rst` is high (0 = standard, 1 = fall-through), and later changes of the pin have no effect. In standard mode a flag pin is 1 when there is room and 0 when the queue is full. In fall-through mode it is 0 when there is room and 1 when the queue is full.
- R2: After reset, every occupancy is zero, every per-queue flag and `comp_flag` show the room level of the captured mode, and `mem_we` is 0.
- R3: In standard mode a queue becomes full after DEPTH accepted writes. Its flag changes right after the clock edge that accepts the filling write.
- R4: In fall-through mode a queue becomes full after DEPTH+1 accepted writes, one more than in standard mode.
- R5: A write to a queue whose flag shows full is dropped. No `mem_we` pulse is issued and that queue's pointer does not advance.
- R6: A completion event (`rd_done` with queue `rd_q`) sampled at clock edge j frees one word of that queue at edge j+2. If the queue was full, its flag shows room right after edge j+2 and not earlier.
- R7: When `wq_sel` changes and is sampled at edge s, `comp_flag` shows the new queue's state right after edge s+1. Until then it shows the old queue's state.
- R8: Each accepted write drives `mem_we`=1 for the cycle after its accepting edge. In that cycle, `mem_q` gives the queue, `mem_ptr` the pointer value before the write, and `mem_wdata` the word. Each queue's pointer starts at 0 and wraps from DEPTH-1 to 0.
- R9: Queues are independent. Writes to or releases from one queue do not change any other queue's flag or pointer.
- R10: A completion event for a queue with zero occupancy is ignored. The occupancy does not wrap, and the flag stays at the room level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high master reset |
| fwft_mode | input | 1 | Mode select, captured during reset |
| wq_sel | input | QW | Queue targeted by the write port |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| rd_done | input | 1 | Read completion event, write-clock synchronous |
| rd_q | input | QW | Queue of the completion event |
| mem_we | output | 1 | Storage write strobe |
| mem_q | output | QW | Storage queue index |
| mem_ptr | output | PW | Storage location within the queue |
| mem_wdata | output | DW | Storage write word |
| q_flag | output | NQ | Per-queue space flag, polarity by mode |
| comp_flag | output | 1 | Space flag of the selected queue |

## Verification
The bench fills one queue exactly to its limit in each mode. If the threshold is off by one, the flag moves one write early or late, or the fall-through mode ignores the extra slot. The bench writes while a queue is full, and also in the same cycle as a completion event. A design that checks the release too early would accept that word, pulse `mem_we` and skip a pointer value. The bench samples the release and the composite switch on every cycle around the event, so a missing or extra pipeline stage shows up as a flag that changes one cycle off. It also sends a completion event to an empty queue, which exposes an occupancy that wraps and reports the queue full. Finally, it toggles the mode pin after reset, which catches a design that does not hold the captured mode.

// File: rtl/mqw_pkg.sv
package mqw_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } mode_e;

    // Pin level seen by the user for a given internal full state.
    function automatic logic pin_level(input logic full, input mode_e m);
        return (m == MODE_FWFT) ? full : ~full;
    endfunction

    // Number of words a queue can hold in a given mode.
    function automatic int unsigned cap_limit(input int unsigned depth, input mode_e m);
        return (m == MODE_FWFT) ? depth + 1 : depth;
    endfunction

endpackage

// File: rtl/mqw_release_pipe.sv
module mqw_release_pipe
    import mqw_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int STAGES = 2,
    localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ev_valid,
    input  logic [QW-1:0] ev_q,
    output logic [NQ-1:0] rel_vec
);
    typedef struct packed {
        logic          v;
        logic [QW-1:0] q;
    } rel_ev_t;

    rel_ev_t stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= '{v: ev_valid, q: ev_q};
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    for (genvar g = 0; g < NQ; g++) begin : g_dec
        assign rel_vec[g] = stage[STAGES-1].v && (stage[STAGES-1].q == QW'(g));
    end

endmodule

// File: rtl/mqw_queue_slot.sv
module mqw_queue_slot
    import mqw_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int OW   = $clog2(DEPTH + 2),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          wr_hit,
    input  logic          rel,
    output logic [OW-1:0] occ,
    output logic [PW-1:0] ptr,
    output logic          full,
    output logic          full_nxt
);
    logic          wr_ok;
    logic          rel_ok;
    logic [OW-1:0] occ_nxt;
    logic [OW-1:0] lim;

    assign lim     = OW'(cap_limit(DEPTH, mode));
    assign wr_ok   = wr_hit && !full;
    assign rel_ok  = rel && (occ != '0);

    always_comb begin
        occ_nxt = occ;
        if (wr_ok && !rel_ok)      occ_nxt = occ + OW'(1);
        else if (!wr_ok && rel_ok) occ_nxt = occ - OW'(1);
    end

    assign full_nxt = (occ_nxt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            occ  <= '0;
            ptr  <= '0;
            full <= 1'b0;
        end else begin
            occ  <= occ_nxt;
            full <= full_nxt;
            if (wr_ok) ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
        end
    end

endmodule

// File: rtl/mqw_composite.sv
module mqw_composite #(
    parameter int NQ   = 4,
    localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] sel,
    input  logic [NQ-1:0] full_nxt_vec,
    output logic [QW-1:0] sel_r,
    output logic          comp_full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_r     <= '0;
            comp_full <= 1'b0;
        end else begin
            sel_r     <= sel;
            comp_full <= full_nxt_vec[sel_r];
        end
    end
endmodule

// File: rtl/mqw_write_port.sv
module mqw_write_port
    import mqw_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 40,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OW   = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic [QW-1:0] wq_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_done,
    input  logic [QW-1:0] rd_q,
    output logic          mem_we,
    output logic [QW-1:0] mem_q,
    output logic [PW-1:0] mem_ptr,
    output logic [DW-1:0] mem_wdata,
    output logic [NQ-1:0] q_flag,
    output logic          comp_flag
);
    mode_e                    mode_r;
    logic [NQ-1:0]            full_st;
    logic [NQ-1:0]            full_nxt;
    logic [NQ-1:0]            rel_vec;
    logic [NQ-1:0][OW-1:0]    occ_vec;
    logic [NQ-1:0][PW-1:0]    ptr_vec;
    logic [QW-1:0]            sel_r;
    logic                     comp_full;
    logic                     acc;

    always_ff @(posedge clk) begin
        if (rst) mode_r <= mode_e'(fwft_mode);
    end

    assign acc = wr_en && !full_st[wq_sel];

    mqw_release_pipe #(.NQ(NQ), .STAGES(2)) u_rel (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (rd_done),
        .ev_q     (rd_q),
        .rel_vec  (rel_vec)
    );

    for (genvar g = 0; g < NQ; g++) begin : g_q
        mqw_queue_slot #(.DEPTH(DEPTH)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .mode     (mode_r),
            .wr_hit   (acc && (wq_sel == QW'(g))),
            .rel      (rel_vec[g]),
            .occ      (occ_vec[g]),
            .ptr      (ptr_vec[g]),
            .full     (full_st[g]),
            .full_nxt (full_nxt[g])
        );
        assign q_flag[g] = pin_level(full_st[g], mode_r);
    end

    mqw_composite #(.NQ(NQ)) u_comp (
        .clk          (clk),
        .rst          (rst),
        .sel          (wq_sel),
        .full_nxt_vec (full_nxt),
        .sel_r        (sel_r),
        .comp_full    (comp_full)
    );

    assign comp_flag = pin_level(comp_full, mode_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_q     <= '0;
            mem_ptr   <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= acc;
            if (acc) begin
                mem_q     <= wq_sel;
                mem_ptr   <= ptr_vec[wq_sel];
                mem_wdata <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mqw_write_port_chk.sv
module mqw_write_port_chk
    import mqw_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DEPTH = 8,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int OW   = $clog2(DEPTH + 2)
) (
    input logic                  clk,
    input logic                  rst,
    input mode_e                 mode_r,
    input logic [NQ-1:0]         full_st,
    input logic [NQ-1:0][OW-1:0] occ_vec,
    input logic                  comp_full,
    input logic                  mem_we,
    input logic [QW-1:0]         mem_q,
    input logic [QW-1:0]         wq_sel,
    input logic                  rd_done,
    input logic [QW-1:0]         rd_q
);
    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != '1) cyc <= cyc + 3'd1;
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd1) |-> $stable(mode_r)); // R1

    AST_RESET_READY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (full_st == '0 && !comp_full && !mem_we)); // R2

    AST_COMP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3'd3) |-> (comp_full == full_st[$past(wq_sel, 2)])); // R7

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            occ_vec[g] <= OW'(cap_limit(DEPTH, mode_r))); // R5

        AST_FILL_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 3'd1 && $rose(full_st[g])) |-> (mem_we && mem_q == QW'(g))); // R3

        AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (rst)
            (cyc >= 3'd4 && $fell(full_st[g])) |-> $past(rd_done && rd_q == QW'(g), 3)); // R6
    end

endmodule

bind mqw_write_port mqw_write_port_chk #(.NQ(NQ), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_r    (mode_r),
    .full_st   (full_st),
    .occ_vec   (occ_vec),
    .comp_full (comp_full),
    .mem_we    (mem_we),
    .mem_q     (mem_q),
    .wq_sel    (wq_sel),
    .rd_done   (rd_done),
    .rd_q      (rd_q)
);

// File: tb/sim_mqw_write_port.sv
`timescale 1ns/1ps
module sim_mqw_write_port;
    localparam int NQ    = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 40;
    localparam int QW    = 2;
    localparam int PW    = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          fwft_mode;
    logic [QW-1:0] wq_sel;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_done;
    logic [QW-1:0] rd_q;
    logic          mem_we;
    logic [QW-1:0] mem_q;
    logic [PW-1:0] mem_ptr;
    logic [DW-1:0] mem_wdata;
    logic [NQ-1:0] q_flag;
    logic          comp_flag;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mqw_write_port #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .fwft_mode(fwft_mode), .wq_sel(wq_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_done(rd_done), .rd_q(rd_q),
        .mem_we(mem_we), .mem_q(mem_q), .mem_ptr(mem_ptr), .mem_wdata(mem_wdata),
        .q_flag(q_flag), .comp_flag(comp_flag)
    );

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [QW-1:0] rq;
        logic [NQ-1:0] eflag;
        logic          ecomp;
        logic          ewe;
        logic [PW-1:0] eptr;
    } vec_t;

    // Standard mode, queue 0 selected throughout, DEPTH = 4.
    localparam vec_t TBL [12] = '{
        '{1'b1, 1'b0, 2'd0, 4'hF, 1'b1, 1'b1, 2'd0},
        '{1'b1, 1'b0, 2'd0, 4'hF, 1'b1, 1'b1, 2'd1},
        '{1'b1, 1'b0, 2'd0, 4'hF, 1'b1, 1'b1, 2'd2},
        '{1'b1, 1'b0, 2'd0, 4'hE, 1'b0, 1'b1, 2'd3},
        '{1'b1, 1'b0, 2'd0, 4'hE, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b1, 2'd0, 4'hE, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b0, 2'd0, 4'hE, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b0, 2'd0, 4'hF, 1'b1, 1'b0, 2'd0},
        '{1'b1, 1'b0, 2'd0, 4'hE, 1'b0, 1'b1, 2'd0},
        '{1'b1, 1'b1, 2'd0, 4'hE, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b0, 2'd0, 4'hE, 1'b0, 1'b0, 2'd0},
        '{1'b0, 1'b0, 2'd0, 4'hF, 1'b1, 1'b0, 2'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock edge; returns 2 ns after it, when outputs are stable.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs();
        wr_en   = 1'b0;
        rd_done = 1'b0;
    endtask

    task automatic do_reset(input logic mode, input logic [QW-1:0] sel);
        rst       = 1'b1;
        fwft_mode = mode;
        wq_sel    = sel;
        wr_data   = '0;
        rd_q      = '0;
        idle_inputs();
        repeat (3) step();
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0, 2'd0);
        chk("R2", "std reset q_flag", 64'(q_flag), 64'hF);
        chk("R2", "std reset comp_flag", 64'(comp_flag), 64'h1);
        chk("R2", "std reset mem_we", 64'(mem_we), 64'h0);

        for (int i = 0; i < 12; i++) begin
            wr_en   = TBL[i].wr;
            wr_data = DW'(40'hA0 + i);
            rd_done = TBL[i].rd;
            rd_q    = TBL[i].rq;
            step();
            idle_inputs();
            chk("R3/R6 r3_r6", $sformatf("vec %0d q_flag", i), 64'(q_flag), 64'(TBL[i].eflag));
            chk("R7", $sformatf("vec %0d comp_flag", i), 64'(comp_flag), 64'(TBL[i].ecomp));
            chk("R5", $sformatf("vec %0d mem_we", i), 64'(mem_we), 64'(TBL[i].ewe));
            if (TBL[i].ewe) begin
                chk("R8", $sformatf("vec %0d mem_ptr", i), 64'(mem_ptr), 64'(TBL[i].eptr));
                chk("R8", $sformatf("vec %0d mem_wdata", i), 64'(mem_wdata), 64'(40'hA0 + i));
                chk("R8", $sformatf("vec %0d mem_q", i), 64'(mem_q), 64'h0);
            end
        end

        // ---------------- fall-through mode ----------------
        do_reset(1'b1, 2'd1);
        chk("R2", "fwft reset q_flag", 64'(q_flag), 64'h0);
        chk("R2", "fwft reset comp_flag", 64'(comp_flag), 64'h0);

        // R4: DEPTH+1 = 5 writes to queue 1 to fill
        for (int i = 0; i < 5; i++) begin
            wr_en   = 1'b1;
            wr_data = DW'(40'h500 + i);
            step();
            idle_inputs();
            chk("R4", $sformatf("fwft write %0d mem_we", i), 64'(mem_we), 64'h1);
            chk("R4", $sformatf("fwft write %0d q_flag", i), 64'(q_flag),
                (i == 4) ? 64'h2 : 64'h0);
        end
        chk("R8", "fwft pointer wrap", 64'(mem_ptr), 64'h0);
        chk("R7", "comp shows q1 full", 64'(comp_flag), 64'h1);

        // R5: sixth write dropped
        wr_en = 1'b1;
        step();
        idle_inputs();
        chk("R5", "fwft overfill mem_we", 64'(mem_we), 64'h0);
        chk("R5", "fwft overfill q_flag", 64'(q_flag), 64'h2);

        // R7: switch select to queue 2
        wq_sel = 2'd2;
        step();
        chk("R7", "comp one edge after select", 64'(comp_flag), 64'h1);
        step();
        chk("R7", "comp two edges after select", 64'(comp_flag), 64'h0);

        // R6: release queue 1, flag returns after edge j+2
        rd_done = 1'b1;
        rd_q    = 2'd1;
        step();
        idle_inputs();
        chk("R6", "release edge j", 64'(q_flag[1]), 64'h1);
        step();
        chk("R6", "release edge j+1", 64'(q_flag[1]), 64'h1);
        step();
        chk("R6", "release edge j+2", 64'(q_flag[1]), 64'h0);

        // R10: release to empty queue 3 ignored
        rd_done = 1'b1;
        rd_q    = 2'd3;
        step();
        idle_inputs();
        repeat (3) step();
        chk("R10", "empty release q_flag", 64'(q_flag), 64'h0);

        // R1: mode pin change after reset has no effect
        fwft_mode = 1'b0;
        repeat (2) step();
        chk("R1", "mode held q_flag", 64'(q_flag), 64'h0);
        chk("R1", "mode held comp_flag", 64'(comp_flag), 64'h0);

        // R9: write to queue 2, other queues unaffected
        wr_en   = 1'b1;
        wr_data = DW'(40'h777);
        step();
        idle_inputs();
        chk("R9", "q2 write mem_q", 64'(mem_q), 64'h2);
        chk("R9", "q2 write mem_ptr", 64'(mem_ptr), 64'h0);
        chk("R9", "q2 write q_flag", 64'(q_flag), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule